// File: doc/BRIEF.md
# Quadrature Encoder Position Tracker

This block follows the shaft angle of a rotary encoder. It takes the two phase signals of the encoder straight from the pins. These signals are asynchronous to the system clock, so each one first passes through a short synchronizer chain. The block then compares the current two-bit phase code with the code from the previous cycle. A legal one-step move along the Gray cycle moves a position register up or down by one count.

The position stays inside a modular range from 0 to a parameterized maximum, which defaults to 360. Because this range is not a power of two, each end has its own wrap rule. A direction flag records which way the last accepted step went. A jump of two phase positions in one cycle cannot be resolved, so it is discarded.

Both outputs come from registers and share a single synchronous active-low reset. The block is meant to sit beside a motor or knob interface. It gives a ready-to-use angle count with no software involvement.

Top module: `qpt_tracker`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `position` becomes 0 and `direction` becomes 0.
- R2: `position` is 9 bits wide and never holds a value above 360.
- R3: With the phase code taken as {enc_a, enc_b}, a synchronized move 00→01, 01→11, 11→10 or 10→00 is a forward step. A forward step adds one to `position` and sets `direction` to 1.
- R4: A synchronized move 01→00, 11→01, 10→11 or 00→10 is a reverse step. A reverse step subtracts one from `position` and clears `direction` to 0.
- R5: A forward step taken while `position` is 360 gives 0.
- R6: A reverse step taken while `position` is 0 gives 360.
- R7: A move in which both phase bits change in the same synchronized cycle (00↔11, 01↔10) is not counted. Both `position` and `direction` keep their values.
- R8: When the synchronized phase code does not change, `position` and `direction` hold their values.
- R9: Suppose a change on the raw phase inputs is set up before rising edge n. The outputs still show the old values after edge n+1 and show the new values after edge n+2. This comes from two synchronizer stages and one output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_a | input | 1 | Raw encoder phase A, asynchronous |
| enc_b | input | 1 | Raw encoder phase B, asynchronous |
| position | output | 9 | Current angle count, 0 to 360 |
| direction | output | 1 | 1 after a forward step, 0 after a reverse step |

## Verification
The bench builds the tracker with its defaults: a top count of 360 and a two-stage synchronizer. With these values, a directed run of 361 forward steps walks the full circle and crosses the upper wrap. A single reverse step out of reset reaches the lower wrap right away. The two-stage chain fixes the latency at three edges, so the bench can test the R9 window exactly. Random phase codes mix legal steps, illegal double-bit jumps and repeats, and a reset in mid-run follows.

// File: rtl/qpt_pkg.sv
package qpt_pkg;

  // Map a Gray-coded phase pair {a,b} onto its place in the cycle 0..3
  function automatic logic [1:0] phase_index(input logic [1:0] ab);
    return {ab[1], ab[1] ^ ab[0]};
  endfunction

  typedef enum logic [1:0] {
    MOVE_NONE = 2'd0,
    MOVE_FWD  = 2'd1,
    MOVE_BAD  = 2'd2,
    MOVE_REV  = 2'd3
  } move_e;

endpackage

// File: rtl/qpt_sync.sv
module qpt_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= raw_in;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/qpt_step_decode.sv
module qpt_step_decode
  import qpt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] phase_cur,
  output logic       step_fwd,
  output logic       step_rev
);

  logic [1:0] phase_prev;
  logic [1:0] delta;
  move_e      move;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_prev <= 2'b00;
    else        phase_prev <= phase_cur;
  end

  always_comb begin
    delta = phase_index(phase_cur) - phase_index(phase_prev);
    move  = move_e'(delta);
  end

  assign step_fwd = (move == MOVE_FWD);
  assign step_rev = (move == MOVE_REV);

  // R7
  step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_fwd, step_rev}));

  // R7
  double_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_cur ^ phase_prev) == 2'b11) |-> (!step_fwd && !step_rev));

endmodule

// File: rtl/qpt_pos_counter.sv
module qpt_pos_counter #(
  parameter int POS_MAX = 360,
  parameter int POS_W   = $clog2(POS_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_fwd,
  input  logic             step_rev,
  output logic [POS_W-1:0] pos,
  output logic             dir
);

  localparam logic [POS_W-1:0] TOP = POS_W'(POS_MAX);

  logic at_top, at_floor;

  assign at_top   = (pos == TOP);
  assign at_floor = (pos == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos <= '0;
      dir <= 1'b0;
    end else if (step_fwd) begin
      pos <= at_top ? '0 : pos + 1'b1;
      dir <= 1'b1;
    end else if (step_rev) begin
      pos <= at_floor ? TOP : pos - 1'b1;
      dir <= 1'b0;
    end
  end

  // R2
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= TOP);

  // R5
  top_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fwd && at_top) |=> (pos == '0));

  // R6
  floor_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_rev && at_floor) |=> (pos == TOP));

  // R3
  fwd_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_fwd |=> dir);

  // R4
  rev_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_rev |=> !dir);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_fwd && !step_rev) |=> ($stable(pos) && $stable(dir)));

endmodule

// File: rtl/qpt_tracker.sv
module qpt_tracker #(
  parameter int POS_MAX     = 360,
  parameter int SYNC_STAGES = 2,
  parameter int POS_W       = $clog2(POS_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  output logic [POS_W-1:0] position,
  output logic             direction
);

  logic [1:0] phase_sync;
  logic       fwd, rev;

  qpt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   ({enc_a, enc_b}),
    .sync_out (phase_sync)
  );

  qpt_step_decode u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_cur (phase_sync),
    .step_fwd  (fwd),
    .step_rev  (rev)
  );

  qpt_pos_counter #(.POS_MAX(POS_MAX), .POS_W(POS_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_fwd (fwd),
    .step_rev (rev),
    .pos      (position),
    .dir      (direction)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (position == '0 && !direction));

endmodule

// File: tb/qpt_tracker_bench.sv
`timescale 1ns/1ps
module qpt_tracker_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enc_a = 1'b0;
  logic       enc_b = 1'b0;
  logic [8:0] position;
  logic       direction;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int         exp_pos = 0;
  logic       exp_dir = 1'b0;
  logic [1:0] last_ab = 2'b00;

  always #2 clk = ~clk;

  qpt_tracker u_qpt_tracker (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .position(position), .direction(direction)
  );

  function automatic int step_of(input logic [1:0] p, input logic [1:0] c);
    if ((p == 2'b00 && c == 2'b01) || (p == 2'b01 && c == 2'b11) ||
        (p == 2'b11 && c == 2'b10) || (p == 2'b10 && c == 2'b00)) return 1;
    if ((p == 2'b01 && c == 2'b00) || (p == 2'b11 && c == 2'b01) ||
        (p == 2'b10 && c == 2'b11) || (p == 2'b00 && c == 2'b10)) return -1;
    return 0;
  endfunction

  function automatic int next_pos(input int p, input int s);
    if (s == 1)  return (p == 360) ? 0 : p + 1;
    if (s == -1) return (p == 0) ? 360 : p - 1;
    return p;
  endfunction

  task automatic check(input string req, input int act_p, input int want_p,
                       input logic act_d, input logic want_d);
    checks++;
    if (act_p != want_p || act_d != want_d) begin
      fails++;
      $display("FAIL %s: position=%0d direction=%0b, expected position=%0d direction=%0b",
               req, act_p, act_d, want_p, want_d);
    end
  endtask

  task automatic model_step(input logic [1:0] ab);
    int s;
    s = step_of(last_ab, ab);
    exp_pos = next_pos(exp_pos, s);
    if (s == 1)  exp_dir = 1'b1;
    if (s == -1) exp_dir = 1'b0;
    last_ab = ab;
  endtask

  // Drive a new raw code and check the outputs three edges later
  task automatic apply(input logic [1:0] ab, input string req);
    @(negedge clk);
    {enc_a, enc_b} = ab;
    repeat (3) @(posedge clk);
    @(negedge clk);
    model_step(ab);
    check(req, position, exp_pos, direction, exp_dir);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    exp_pos = 0; exp_dir = 1'b0; last_ab = 2'b00;
    check("R1", position, 0, direction, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    model_step({enc_a, enc_b});
    check("R1", position, exp_pos, direction, exp_dir);
  endtask

  initial begin
    int old_p;
    logic old_d;
    logic [1:0] seq_f [4];
    logic [1:0] r;
    seq_f[0] = 2'b01; seq_f[1] = 2'b11; seq_f[2] = 2'b10; seq_f[3] = 2'b00;
    void'($urandom(32'd2024));

    do_reset();

    // R6: reverse from 0 wraps to 360
    apply(2'b10, "R6");
    // R4: further reverse steps count down
    apply(2'b11, "R4");
    apply(2'b01, "R4");
    // R3: forward steps count up and set direction
    apply(2'b11, "R3");
    apply(2'b10, "R3");
    // R8: repeat the same code
    apply(2'b10, "R8");
    // R7: double-bit jump ignored, direction kept
    apply(2'b01, "R7");
    apply(2'b10, "R7");

    // R9: latency of the output update
    @(negedge clk);
    old_p = position; old_d = direction;
    {enc_a, enc_b} = 2'b00;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9", position, old_p, direction, old_d);
    @(posedge clk);
    @(negedge clk);
    model_step(2'b00);
    check("R9", position, exp_pos, direction, exp_dir);

    // R5: full forward circle crossing 360 -> 0
    for (int k = 0; k < 370; k++) begin
      apply(seq_f[k % 4], (exp_pos == 360) ? "R5" : "R3");
      if (position > 9'd360) begin
        checks++; fails++;
        $display("FAIL R2: position=%0d, expected at most 360", position);
      end
    end

    // Random mix of legal, illegal and repeated codes
    for (int k = 0; k < 1500; k++) begin
      r = 2'($urandom());
      apply(r, "R3/R4/R7/R8");
      checks++;
      if (position > 9'd360) begin
        fails++;
        $display("FAIL R2: position=%0d, expected at most 360", position);
      end
    end

    // Mid-run reset
    do_reset();
    apply(2'b01, "R3");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule